// File: doc/BRIEF.md
# Cumulative Charge Excess Detector

This block watches the supply charge drawn by a device under test while a pattern sequence runs, one pattern per clock. For every supply port it keeps a running sum of the charge samples. Alongside these sums it keeps a running sum of a reference increment, which traces the worst-case charge curve of known-good dies. After every pattern it forms, for each port, the amount by which the measured total lies above the reference total. If any port's excess is larger than a programmable threshold, the block raises a detection flag. It also records which port crossed and at which pattern number.

A large anomaly crosses the threshold after only a few patterns. A small one needs a long run before its excess builds up, so the recorded pattern number shows how strong the deviation is. The check is made on every pattern as the sequence runs, not only at the end. The reference increment arrives as a stream input together with each set of port samples. A start pulse opens a new measurement run.

Top module: `charge_excess_detector`

## Requirements
- R1: While reset is held, and right after it, `detected` is 0, `patternCount` is 0, `refCharge` is 0 and every port total is 0.
- R2: On each clock edge with `sampleValid` high and `start` low, each port total grows by that port's sample, the reference total grows by `refIncr`, and `patternCount` grows by one. Port p's sample is bits [p*SAMPLE_W +: SAMPLE_W] of `samples`, and port p's total is bits [p*ACC_W +: ACC_W] of `portCharge`.
- R3: Port totals and the reference total are unsigned and saturate at 2^ACC_W-1 instead of wrapping.
- R4: A clock edge with `sampleValid` low and `start` low changes no total, no count and no detection output, whatever the sample inputs hold.
- R5: A port's excess is its total minus the reference total, counted as 0 when the reference total is larger. A port trips only when its excess is strictly greater than `threshold`.
- R6: Once `detected` is set, it stays set, and `tripPort` and `tripCount` hold their values, until the next `start`. Later trips on any port do not change them.
- R7: When more than one port trips on the same pattern, `tripPort` reports the lowest port index.
- R8: A `start` edge clears all totals, the pattern count and the detection state. When `start` and `sampleValid` are high on the same edge, `start` wins and the sample is dropped.
- R9: `patternCount` saturates at 2^CNT_W-1.
- R10: The compare uses the totals that include the current pattern. `detected` is set on the same edge that adds the tripping pattern, and `tripCount` equals the `patternCount` value after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one pattern per cycle |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begins a new run: clears totals, count and detection |
| sampleValid | input | 1 | The samples and the reference increment are valid for one pattern |
| samples | input | NUM_PORTS*SAMPLE_W | Per-port charge samples, port 0 in the low bits |
| refIncr | input | SAMPLE_W | Worst-case reference charge increment for this pattern |
| threshold | input | ACC_W | Excess limit; a port trips when its excess is strictly above it |
| detected | output | 1 | Latched detection flag |
| tripPort | output | PORT_W | Index of the port that tripped |
| tripCount | output | CNT_W | Pattern number at which the trip occurred |
| patternCount | output | CNT_W | Patterns accumulated since start |
| refCharge | output | ACC_W | Accumulated reference charge |
| portCharge | output | NUM_PORTS*ACC_W | Accumulated charge per port, port 0 in the low bits |

## Verification
The bench builds the block with four ports and 16-bit samples. It narrows the totals to 20 bits and the pattern count to 8 bits. With those widths, seventeen full-scale samples are enough to saturate a total, and 260 patterns are enough to saturate the count. Both clamps can then be checked at the ports in a short run. The threshold runs a tie on a single port and a tie between two ports. It also runs a negative difference that must read as zero, an excess exactly equal to the limit, and a start pulse that arrives with a valid pattern.

// File: rtl/cxd_pkg.sv
`timescale 1ns/1ps
package cxd_pkg;
  // strobes from control to datapath, one cycle each
  typedef struct packed {
    logic clearAll;  // new run: zero every total and the counter
    logic advance;   // fold this pattern into the totals
    logic capture;   // record trip port and pattern number
  } cxdStrobe_t;
endpackage

// File: rtl/cxd_port_acc.sv
`timescale 1ns/1ps
module cxd_port_acc #(
  parameter int SAMPLE_W = 16,
  parameter int ACC_W    = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                clearAll,
  input  logic                advance,
  input  logic [SAMPLE_W-1:0] sample,
  input  logic [ACC_W-1:0]    refNext,
  input  logic [ACC_W-1:0]    threshold,
  output logic [ACC_W-1:0]    acc,
  output logic                tripNext
);
  localparam logic [ACC_W-1:0] ACC_MAX = '1;

  logic [ACC_W:0]   wideSum;
  logic [ACC_W-1:0] accNext;
  logic [ACC_W-1:0] excess;

  always_comb begin
    wideSum = {1'b0, acc} + {{(ACC_W + 1 - SAMPLE_W){1'b0}}, sample};
    accNext = wideSum[ACC_W] ? ACC_MAX : wideSum[ACC_W-1:0];
    excess  = (accNext > refNext) ? (accNext - refNext) : '0;
    tripNext = (excess > threshold);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         acc <= '0;
    else if (clearAll) acc <= '0;
    else if (advance)  acc <= accNext;
  end
endmodule

// File: rtl/cxd_datapath.sv
`timescale 1ns/1ps
module cxd_datapath
  import cxd_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int SAMPLE_W  = 16,
  parameter int ACC_W     = 32,
  parameter int CNT_W     = 16,
  localparam int PORT_W   = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  cxdStrobe_t                    strobe,
  input  logic [NUM_PORTS*SAMPLE_W-1:0] samples,
  input  logic [SAMPLE_W-1:0]           refIncr,
  input  logic [ACC_W-1:0]              threshold,
  output logic                          anyTrip,
  output logic [PORT_W-1:0]             tripPort,
  output logic [CNT_W-1:0]              tripCount,
  output logic [CNT_W-1:0]              patternCount,
  output logic [ACC_W-1:0]              refCharge,
  output logic [NUM_PORTS*ACC_W-1:0]    portCharge
);
  localparam logic [ACC_W-1:0] ACC_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [ACC_W:0]        refWide;
  logic [ACC_W-1:0]      refNext;
  logic [CNT_W-1:0]      cntNext;
  logic [NUM_PORTS-1:0]  tripVec;
  logic [PORT_W-1:0]     lowIdx;

  // reference envelope accumulation, saturating
  always_comb begin
    refWide = {1'b0, refCharge} + {{(ACC_W + 1 - SAMPLE_W){1'b0}}, refIncr};
    refNext = refWide[ACC_W] ? ACC_MAX : refWide[ACC_W-1:0];
    cntNext = (patternCount == CNT_MAX) ? CNT_MAX : patternCount + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      refCharge    <= '0;
      patternCount <= '0;
    end else if (strobe.clearAll) begin
      refCharge    <= '0;
      patternCount <= '0;
    end else if (strobe.advance) begin
      refCharge    <= refNext;
      patternCount <= cntNext;
    end
  end

  // one saturating integrator per supply port
  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    cxd_port_acc #(
      .SAMPLE_W(SAMPLE_W),
      .ACC_W   (ACC_W)
    ) u_acc (
      .clk      (clk),
      .rstN     (rstN),
      .clearAll (strobe.clearAll),
      .advance  (strobe.advance),
      .sample   (samples[p*SAMPLE_W +: SAMPLE_W]),
      .refNext  (refNext),
      .threshold(threshold),
      .acc      (portCharge[p*ACC_W +: ACC_W]),
      .tripNext (tripVec[p])
    );
  end

  // lowest tripping index wins
  always_comb begin
    lowIdx = '0;
    for (int i = NUM_PORTS - 1; i >= 0; i--) begin
      if (tripVec[i]) lowIdx = PORT_W'(i);
    end
  end

  assign anyTrip = |tripVec;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tripPort  <= '0;
      tripCount <= '0;
    end else if (strobe.clearAll) begin
      tripPort  <= '0;
      tripCount <= '0;
    end else if (strobe.capture) begin
      tripPort  <= lowIdx;
      tripCount <= cntNext;
    end
  end
endmodule

// File: rtl/cxd_control.sv
`timescale 1ns/1ps
module cxd_control
  import cxd_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       sampleValid,
  input  logic       anyTrip,
  output cxdStrobe_t strobe,
  output logic       detected
);
  always_comb begin
    strobe.clearAll = start;
    strobe.advance  = sampleValid & ~start;
    strobe.capture  = sampleValid & ~start & anyTrip & ~detected;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               detected <= 1'b0;
    else if (strobe.clearAll) detected <= 1'b0;
    else if (strobe.capture)  detected <= 1'b1;
  end
endmodule

// File: rtl/charge_excess_detector.sv
`timescale 1ns/1ps
module charge_excess_detector
  import cxd_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int SAMPLE_W  = 16,
  parameter int ACC_W     = 32,
  parameter int CNT_W     = 16,
  localparam int PORT_W   = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          start,
  input  logic                          sampleValid,
  input  logic [NUM_PORTS*SAMPLE_W-1:0] samples,
  input  logic [SAMPLE_W-1:0]           refIncr,
  input  logic [ACC_W-1:0]              threshold,
  output logic                          detected,
  output logic [PORT_W-1:0]             tripPort,
  output logic [CNT_W-1:0]              tripCount,
  output logic [CNT_W-1:0]              patternCount,
  output logic [ACC_W-1:0]              refCharge,
  output logic [NUM_PORTS*ACC_W-1:0]    portCharge
);
  cxdStrobe_t strobe;
  logic       anyTrip;

  cxd_control u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .start      (start),
    .sampleValid(sampleValid),
    .anyTrip    (anyTrip),
    .strobe     (strobe),
    .detected   (detected)
  );

  cxd_datapath #(
    .NUM_PORTS(NUM_PORTS),
    .SAMPLE_W (SAMPLE_W),
    .ACC_W    (ACC_W),
    .CNT_W    (CNT_W)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .samples     (samples),
    .refIncr     (refIncr),
    .threshold   (threshold),
    .anyTrip     (anyTrip),
    .tripPort    (tripPort),
    .tripCount   (tripCount),
    .patternCount(patternCount),
    .refCharge   (refCharge),
    .portCharge  (portCharge)
  );
endmodule

// File: rtl/cxd_checker.sv
`timescale 1ns/1ps
module cxd_checker #(
  parameter int NUM_PORTS = 4,
  parameter int ACC_W     = 32,
  parameter int CNT_W     = 16,
  parameter int PORT_W    = 2
) (
  input logic                       clk,
  input logic                       rstN,
  input logic                       start,
  input logic                       sampleValid,
  input logic                       detected,
  input logic [PORT_W-1:0]          tripPort,
  input logic [CNT_W-1:0]           tripCount,
  input logic [CNT_W-1:0]           patternCount,
  input logic [ACC_W-1:0]           refCharge,
  input logic [NUM_PORTS*ACC_W-1:0] portCharge
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  p_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    (sampleValid && !start && patternCount != CNT_MAX)
      |=> patternCount == $past(patternCount) + 1'b1);

  p_ref_monotone_r3: assert property (@(posedge clk) disable iff (!rstN)
    !start |=> refCharge >= $past(refCharge));

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_mono
    p_port_monotone_r3: assert property (@(posedge clk) disable iff (!rstN)
      !start |=> portCharge[p*ACC_W +: ACC_W] >= $past(portCharge[p*ACC_W +: ACC_W]));
  end

  p_idle_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!start && !sampleValid)
      |=> $stable(patternCount) && $stable(portCharge) && $stable(refCharge)
          && $stable(detected));

  p_latched_r6: assert property (@(posedge clk) disable iff (!rstN)
    (detected && !start) |=> detected && $stable(tripPort) && $stable(tripCount));

  p_start_clears_r8: assert property (@(posedge clk) disable iff (!rstN)
    start |=> !detected && patternCount == '0 && refCharge == '0 && portCharge == '0);

  p_count_cap_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!start && patternCount == CNT_MAX) |=> patternCount == CNT_MAX);

  p_trip_here_r10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(detected) |-> tripCount == patternCount && 32'(tripPort) < NUM_PORTS);
endmodule

bind charge_excess_detector cxd_checker #(
  .NUM_PORTS(NUM_PORTS),
  .ACC_W    (ACC_W),
  .CNT_W    (CNT_W),
  .PORT_W   (PORT_W)
) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .start       (start),
  .sampleValid (sampleValid),
  .detected    (detected),
  .tripPort    (tripPort),
  .tripCount   (tripCount),
  .patternCount(patternCount),
  .refCharge   (refCharge),
  .portCharge  (portCharge)
);

// File: tb/sim_charge_excess_detector.sv
`timescale 1ns/1ps
module sim_charge_excess_detector;
  localparam int NP  = 4;
  localparam int SW  = 16;
  localparam int AW  = 20;
  localparam int CW  = 8;
  localparam int PW  = 2;
  localparam longint ACC_MAX = (64'd1 << AW) - 1;
  localparam longint CNT_MAX = (64'd1 << CW) - 1;
  localparam int VW  = 2 + NP*SW + SW;   // {start, valid, s3..s0, ref}
  localparam int NV  = 11;

  // stimulus table, threshold 100; expected values come from the model below
  localparam logic [VW-1:0] VEC [NV] = '{
    {1'b1, 1'b0, 16'd0,   16'd0,   16'd0,   16'd0,   16'd0},   // R8 open run
    {1'b0, 1'b1, 16'd40,  16'd30,  16'd20,  16'd10,  16'd25},  // R2
    {1'b0, 1'b1, 16'd50,  16'd50,  16'd50,  16'd50,  16'd40},  // R2
    {1'b0, 1'b0, 16'd999, 16'd999, 16'd999, 16'd999, 16'd999}, // R4 idle
    {1'b0, 1'b1, 16'd100, 16'd100, 16'd10,  16'd10,  16'd10},  // R7 ports 2,3 trip
    {1'b0, 1'b1, 16'd0,   16'd0,   16'd0,   16'd500, 16'd0},   // R6 latched
    {1'b1, 16'd0 == 0 ? 1'b0 : 1'b0, 16'd0, 16'd0, 16'd0, 16'd0, 16'd0}, // R8
    {1'b0, 1'b1, 16'd0,   16'd0,   16'd0,   16'd0,   16'd50},  // R5 clip to zero
    {1'b0, 1'b1, 16'd150, 16'd0,   16'd150, 16'd0,   16'd0},   // R5 equal, no trip
    {1'b0, 1'b1, 16'd1,   16'd0,   16'd1,   16'd0,   16'd0},   // R7 ports 1,3 trip
    {1'b1, 1'b1, 16'd7,   16'd7,   16'd7,   16'd7,   16'd7}    // R8 start beats valid
  };

  logic                 clk = 1'b0;
  logic                 rstN = 1'b0;
  logic                 start = 1'b0;
  logic                 sampleValid = 1'b0;
  logic [NP*SW-1:0]     samples = '0;
  logic [SW-1:0]        refIncr = '0;
  logic [AW-1:0]        threshold = '0;
  logic                 detected;
  logic [PW-1:0]        tripPort;
  logic [CW-1:0]        tripCount;
  logic [CW-1:0]        patternCount;
  logic [AW-1:0]        refCharge;
  logic [NP*AW-1:0]     portCharge;

  int nChecks = 0;
  int nFail   = 0;

  longint mAcc [NP];
  longint mRef, mCnt, mTrip;
  bit     mDet;
  int     mPort;

  always #2.5 clk = ~clk;

  charge_excess_detector #(
    .NUM_PORTS(NP), .SAMPLE_W(SW), .ACC_W(AW), .CNT_W(CW)
  ) u0 (
    .clk(clk), .rstN(rstN), .start(start), .sampleValid(sampleValid),
    .samples(samples), .refIncr(refIncr), .threshold(threshold),
    .detected(detected), .tripPort(tripPort), .tripCount(tripCount),
    .patternCount(patternCount), .refCharge(refCharge), .portCharge(portCharge)
  );

  task automatic chk(string req, string what, longint act, longint exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic modelClear();
    for (int p = 0; p < NP; p++) mAcc[p] = 0;
    mRef = 0; mCnt = 0; mDet = 0; mPort = 0; mTrip = 0;
  endtask

  task automatic modelStep(bit st, bit va, logic [NP*SW-1:0] smp, logic [SW-1:0] rf);
    longint ex;
    if (st) modelClear();
    else if (va) begin
      for (int p = 0; p < NP; p++) begin
        mAcc[p] += longint'(smp[p*SW +: SW]);
        if (mAcc[p] > ACC_MAX) mAcc[p] = ACC_MAX;
      end
      mRef += longint'(rf);
      if (mRef > ACC_MAX) mRef = ACC_MAX;
      if (mCnt < CNT_MAX) mCnt++;
      if (!mDet) begin
        for (int p = NP - 1; p >= 0; p--) begin
          ex = (mAcc[p] > mRef) ? mAcc[p] - mRef : 0;
          if (ex > longint'(threshold)) begin
            mDet = 1; mPort = p; mTrip = mCnt;
          end
        end
      end
    end
  endtask

  task automatic checkAll(string req);
    chk(req, "detected R6", longint'(detected), longint'(mDet));
    if (mDet) begin
      chk(req, "tripPort R7", longint'(tripPort), longint'(mPort));
      chk(req, "tripCount R10", longint'(tripCount), mTrip);
    end
    chk(req, "patternCount R2", longint'(patternCount), mCnt);
    chk(req, "refCharge R2", longint'(refCharge), mRef);
    for (int p = 0; p < NP; p++)
      chk(req, $sformatf("portCharge[%0d] R2", p), longint'(portCharge[p*AW +: AW]), mAcc[p]);
  endtask

  task automatic drive(bit st, bit va, logic [NP*SW-1:0] smp, logic [SW-1:0] rf, string req);
    @(negedge clk);
    start = st; sampleValid = va; samples = smp; refIncr = rf;
    @(posedge clk);
    #1;
    modelStep(st, va, smp, rf);
    checkAll(req);
    start = 1'b0; sampleValid = 1'b0;
  endtask

  task automatic finishRun();
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    modelClear();
    // R1: reset state, during and after reset
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "detected in reset", longint'(detected), 0);
    chk("R1", "patternCount in reset", longint'(patternCount), 0);
    chk("R1", "portCharge in reset", longint'(portCharge), 0);
    @(negedge clk); rstN = 1'b1;
    @(posedge clk); #1;
    chk("R1", "refCharge after reset", longint'(refCharge), 0);
    chk("R1", "detected after reset", longint'(detected), 0);

    // table walk
    threshold = AW'(100);
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][VW-1], VEC[i][VW-2], VEC[i][VW-3:SW], VEC[i][SW-1:0],
            $sformatf("R2/R5 vec%0d", i));
      if (i == 3) chk("R4", "idle keeps count", longint'(patternCount), 2);
      if (i == 4) begin
        chk("R7", "lowest of ports 2,3", longint'(tripPort), 2);
        chk("R10", "trip at pattern 3", longint'(tripCount), 3);
      end
      if (i == 5) chk("R6", "port held after later trip", longint'(tripPort), 2);
      if (i == 8) chk("R5", "equal excess does not trip", longint'(detected), 0);
      if (i == 9) chk("R7", "lowest of ports 1,3", longint'(tripPort), 1);
      if (i == 10) chk("R8", "start beats valid", longint'(patternCount), 0);
    end

    // R3: saturation of totals with full-scale samples
    threshold = '1;
    drive(1'b1, 1'b0, '0, '0, "R8");
    for (int k = 0; k < 17; k++) drive(1'b0, 1'b1, '1, '1, "R3");
    chk("R3", "port0 saturated", longint'(portCharge[AW-1:0]), ACC_MAX);
    chk("R3", "ref saturated", longint'(refCharge), ACC_MAX);

    // R9: pattern count saturation
    drive(1'b1, 1'b0, '0, '0, "R8");
    for (int k = 0; k < 260; k++) drive(1'b0, 1'b1, '0, '0, "R9");
    chk("R9", "count held at max", longint'(patternCount), CNT_MAX);

    // R10: trip on the very first pattern, threshold 0
    threshold = '0;
    drive(1'b1, 1'b0, '0, '0, "R8");
    drive(1'b0, 1'b1, {16'd0, 16'd5, 16'd0, 16'd0}, 16'd4, "R10");
    chk("R10", "first-pattern trip count", longint'(tripCount), 1);
    chk("R10", "first-pattern trip port", longint'(tripPort), 2);

    finishRun();
  end
endmodule